// File: doc/BRIEF.md
# Sleep and Peripheral Clock-Stop Controller

This block owns the low-power sleep state of a processor core and the clock gating of its on-chip peripherals. When the core issues its sleep-instruction strobe with the standby-select bit clear, the block drops the CPU clock enable on the next edge. It leaves the core's registers alone, so their contents survive the nap. Peripheral clocks and the external clock output stay on, and a two-pin status code reports the sleeping state.

Any interrupt class wakes the core: non-maskable, external request line, encoded level request, or on-chip peripheral. This holds even while the core's interrupt-block bit is set. On a wake the block latches the request's source code and a source-class pattern into two event registers and emits a one-cycle pulse that starts exception handling. A power-on or manual reset request also ends sleep, with no pulse. A strobe that arrives with standby selected is handed on as a one-cycle standby request instead.

A 32-bit module-stop register, written through a simple strobe port and readable at any time, gates the clock of each peripheral separately. Peripherals 31 and 30 are the two serial channels.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: After reset, cpu_clk_en is 1, stat1/stat0 are 0/0, wake_pls and stby_req are 0, the module-stop register reads 0 and every bit of per_clk_en is 1.
- R2: In run, a cycle with sleep_stb=1, stby_sel=0 and no reset request makes cpu_clk_en 0 and stat1/stat0 1/0 from the next edge. In run, stat1/stat0 are 0/0.
- R3: In run, sleep_stb=1 with stby_sel=1 and no reset request raises stby_req for exactly the next cycle, and the block stays in run.
- R4: In sleep, a cycle with any of nmi_req, irq_req, irl_req or per_req high and no reset request returns the block to run on the next edge. wake_pls is then 1 for exactly that one cycle, whatever blk_bit holds.
- R5: On that wake, evt_code takes the req_code sampled with the request, and evt_src takes {nmi_req, irl_req, irq_req, per_req} from the same cycle. Both event registers hold their value at all other times.
- R6: In sleep, por_req or mrst_req returns the block to run on the next edge without a wake pulse, even when an interrupt arrives in the same cycle.
- R7: ms_we=1 loads ms_wdata into the module-stop register at the next edge. ms_rdata then returns it, and per_clk_en[i] equals the inverse of bit i. Bit 31 gates serial channel 1 and bit 30 gates serial channel 0.
- R8: por_req clears the module-stop register at the next edge and takes priority over a write in the same cycle. mrst_req leaves the register unchanged.
- R9: per_clk_en and ckout_en do not depend on the power state. ckout_en is 1 in both run and sleep.
- R10: Interrupt requests in run produce no wake pulse and leave both event registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| por_req | input | 1 | Power-on reset request (synchronous level) |
| mrst_req | input | 1 | Manual reset request (synchronous level) |
| sleep_stb | input | 1 | Sleep-instruction strobe from the core |
| stby_sel | input | 1 | 1 selects standby instead of sleep |
| blk_bit | input | 1 | Core's interrupt-block bit (deliberately ignored for wake-up) |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | External interrupt line request |
| irl_req | input | 1 | Encoded level interrupt request |
| per_req | input | 1 | On-chip peripheral interrupt request |
| req_code | input | CODE_W | Source code of the pending request |
| ms_we | input | 1 | Module-stop register write strobe |
| ms_wdata | input | 32 | Module-stop write data |
| ms_rdata | output | 32 | Module-stop register contents |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | NPER | Per-peripheral clock enables |
| ckout_en | output | 1 | External clock-output enable |
| stat1 | output | 1 | Status pin 1 |
| stat0 | output | 1 | Status pin 0 |
| evt_code | output | CODE_W | Latched interrupt source code |
| evt_src | output | 4 | Latched request class pattern {nmi, irl, irq, per} |
| wake_pls | output | 1 | One-cycle start of interrupt exception handling |
| stby_req | output | 1 | One-cycle request to enter standby |

## Verification
The properties assume that every request, strobe and write input is synchronous to clk, and that reset requests and interrupt requests are plain levels sampled at each edge. They read the power state only through cpu_clk_en, so they take for granted that nothing outside the block forces it. The stimulus changes inputs on the falling edge only. It draws interrupt, strobe and write activity at random, and it keeps reset requests rare so that long run and sleep stretches occur. Directed cycles place a reset request and an interrupt in the same sleep cycle, and a power-on request together with a write.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {
    PS_RUN   = 1'b0,
    PS_SLEEP = 1'b1
  } pwr_st_e;

  // status pin code {stat1, stat0}
  localparam logic [1:0] STAT_RUN   = 2'b00;
  localparam logic [1:0] STAT_SLEEP = 2'b10;

  localparam int unsigned SRC_W  = 4;
  localparam int unsigned MREG_W = 32;
endpackage

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_stb,
  input  logic stby_sel,
  input  logic any_int,
  input  logic rst_req,
  output logic asleep,
  output logic wake_pls,
  output logic stby_req
);
  pwr_st_e st_q, st_d;
  logic    wake_d, stby_d;

  always_comb begin
    st_d   = st_q;
    wake_d = 1'b0;
    stby_d = 1'b0;
    unique case (st_q)
      PS_RUN: begin
        if (!rst_req && sleep_stb) begin
          if (stby_sel) stby_d = 1'b1;
          else          st_d   = PS_SLEEP;
        end
      end
      PS_SLEEP: begin
        if (rst_req) begin
          st_d = PS_RUN;
        end else if (any_int) begin
          st_d   = PS_RUN;
          wake_d = 1'b1;
        end
      end
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_RUN;
      wake_pls <= 1'b0;
      stby_req <= 1'b0;
    end else begin
      st_q     <= st_d;
      wake_pls <= wake_d;
      stby_req <= stby_d;
    end
  end

  assign asleep = (st_q == PS_SLEEP);
endmodule

// File: rtl/slp_evt_latch.sv
module slp_evt_latch
  import slp_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [CODE_W-1:0] code_in,
  input  logic [SRC_W-1:0]  src_in,
  output logic [CODE_W-1:0] code_q,
  output logic [SRC_W-1:0]  src_q
);
  logic [CODE_W-1:0] code_d;
  logic [SRC_W-1:0]  src_d;

  always_comb begin
    code_d = code_q;
    src_d  = src_q;
    if (cap) begin
      code_d = code_in;
      src_d  = src_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      src_q  <= '0;
    end else begin
      code_q <= code_d;
      src_q  <= src_d;
    end
  end
endmodule

// File: rtl/slp_mstp_reg.sv
module slp_mstp_reg
  import slp_pkg::*;
#(
  parameter int unsigned NPER = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [MREG_W-1:0] wdata,
  output logic [MREG_W-1:0] rdata,
  output logic [NPER-1:0]   clk_en
);
  // only implemented peripheral bits are writable
  localparam logic [MREG_W-1:0] WMASK =
    (NPER >= MREG_W) ? {MREG_W{1'b1}} : ((MREG_W'(1) << NPER) - MREG_W'(1));

  logic [MREG_W-1:0] stop_q, stop_d;

  always_comb begin
    stop_d = stop_q;
    if (clr)     stop_d = '0;
    else if (we) stop_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= '0;
    else        stop_q <= stop_d;
  end

  for (genvar i = 0; i < NPER; i++) begin : g_gate
    assign clk_en[i] = ~stop_q[i];
  end

  assign rdata = stop_q;
endmodule

// File: rtl/slp_pwr_ctrl.sv
module slp_pwr_ctrl
  import slp_pkg::*;
#(
  parameter int unsigned NPER   = 32,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_req,
  input  logic              mrst_req,
  input  logic              sleep_stb,
  input  logic              stby_sel,
  input  logic              blk_bit,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic              irl_req,
  input  logic              per_req,
  input  logic [CODE_W-1:0] req_code,
  input  logic              ms_we,
  input  logic [31:0]       ms_wdata,
  output logic [31:0]       ms_rdata,
  output logic              cpu_clk_en,
  output logic [NPER-1:0]   per_clk_en,
  output logic              ckout_en,
  output logic              stat1,
  output logic              stat0,
  output logic [CODE_W-1:0] evt_code,
  output logic [SRC_W-1:0]  evt_src,
  output logic              wake_pls,
  output logic              stby_req
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // the interrupt-block bit has no say over wake-up from sleep
  logic blk_unused;
  assign blk_unused = blk_bit;

  logic             any_int, rst_req, asleep, cap_evt;
  logic [SRC_W-1:0] src_vec;
  logic [1:0]       stat_code;

  assign src_vec = {nmi_req, irl_req, irq_req, per_req};
  assign any_int = |src_vec;
  assign rst_req = por_req | mrst_req;
  assign cap_evt = asleep & any_int & ~rst_req;

  slp_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sleep_stb (sleep_stb),
    .stby_sel  (stby_sel),
    .any_int   (any_int),
    .rst_req   (rst_req),
    .asleep    (asleep),
    .wake_pls  (wake_pls),
    .stby_req  (stby_req)
  );

  slp_evt_latch #(.CODE_W(CODE_W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cap     (cap_evt),
    .code_in (req_code),
    .src_in  (src_vec),
    .code_q  (evt_code),
    .src_q   (evt_src)
  );

  slp_mstp_reg #(.NPER(NPER)) u_mstp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (por_req),
    .we     (ms_we),
    .wdata  (ms_wdata),
    .rdata  (ms_rdata),
    .clk_en (per_clk_en)
  );

  assign cpu_clk_en = ~asleep;
  assign ckout_en   = 1'b1;   // the clock pin keeps running in run and sleep
  assign stat_code  = asleep ? STAT_SLEEP : STAT_RUN;
  assign stat1      = stat_code[1];
  assign stat0      = stat_code[0];
endmodule

// File: rtl/slp_chk.sv
module slp_chk #(
  parameter int unsigned NPER   = 32,
  parameter int unsigned CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_req,
  input logic              mrst_req,
  input logic              sleep_stb,
  input logic              stby_sel,
  input logic              nmi_req,
  input logic              irq_req,
  input logic              irl_req,
  input logic              per_req,
  input logic [CODE_W-1:0] req_code,
  input logic              ms_we,
  input logic [31:0]       ms_wdata,
  input logic [31:0]       ms_rdata,
  input logic              cpu_clk_en,
  input logic [NPER-1:0]   per_clk_en,
  input logic              stat1,
  input logic              stat0,
  input logic [CODE_W-1:0] evt_code,
  input logic              wake_pls,
  input logic              stby_req
);
  logic ints, rreq;
  assign ints = nmi_req | irq_req | irl_req | per_req;
  assign rreq = por_req | mrst_req;

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_stb && !stby_sel && !rreq) |=> (!cpu_clk_en && stat1 && !stat0));

  p_run_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (!stat1 && !stat0));

  p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_stb && stby_sel && !rreq) |=> (stby_req && cpu_clk_en));

  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && ints && !rreq) |=> (wake_pls && cpu_clk_en));

  p_wake_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pls |=> !wake_pls);

  p_evt_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && ints && !rreq) |=> (evt_code == $past(req_code)));

  p_reset_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && rreq) |=> (cpu_clk_en && !wake_pls));

  p_mstp_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_we && !por_req) |=> (per_clk_en == ~($past(ms_wdata[NPER-1:0]))));

  p_por_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> (ms_rdata == 32'd0));

  p_no_run_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |=> !wake_pls);
endmodule

bind slp_pwr_ctrl slp_chk #(.NPER(NPER), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .por_req    (por_req),
  .mrst_req   (mrst_req),
  .sleep_stb  (sleep_stb),
  .stby_sel   (stby_sel),
  .nmi_req    (nmi_req),
  .irq_req    (irq_req),
  .irl_req    (irl_req),
  .per_req    (per_req),
  .req_code   (req_code),
  .ms_we      (ms_we),
  .ms_wdata   (ms_wdata),
  .ms_rdata   (ms_rdata),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .stat1      (stat1),
  .stat0      (stat0),
  .evt_code   (evt_code),
  .wake_pls   (wake_pls),
  .stby_req   (stby_req)
);

// File: tb/sim_slp_pwr_ctrl.sv
module sim_slp_pwr_ctrl;
  localparam int unsigned NPER   = 32;
  localparam int unsigned CODE_W = 12;
  localparam time         CLK_P  = 8ns;

  logic clk, rst_n;
  logic por_req, mrst_req, sleep_stb, stby_sel, blk_bit;
  logic nmi_req, irq_req, irl_req, per_req;
  logic [CODE_W-1:0] req_code;
  logic ms_we;
  logic [31:0] ms_wdata, ms_rdata;
  logic cpu_clk_en, ckout_en, stat1, stat0, wake_pls, stby_req;
  logic [NPER-1:0] per_clk_en;
  logic [CODE_W-1:0] evt_code;
  logic [3:0] evt_src;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // reference model state
  bit          m_sleep;
  logic [31:0] m_stop;
  logic [CODE_W-1:0] m_code;
  logic [3:0]  m_src;
  bit          m_wake, m_stby;

  slp_pwr_ctrl #(.NPER(NPER), .CODE_W(CODE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .por_req(por_req), .mrst_req(mrst_req),
    .sleep_stb(sleep_stb), .stby_sel(stby_sel), .blk_bit(blk_bit),
    .nmi_req(nmi_req), .irq_req(irq_req), .irl_req(irl_req), .per_req(per_req),
    .req_code(req_code), .ms_we(ms_we), .ms_wdata(ms_wdata), .ms_rdata(ms_rdata),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .ckout_en(ckout_en),
    .stat1(stat1), .stat0(stat0), .evt_code(evt_code), .evt_src(evt_src),
    .wake_pls(wake_pls), .stby_req(stby_req)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_stat(input bit slp);
    return slp ? 2'b10 : 2'b00;
  endfunction

  task automatic check_all(input string tag);
    chk(cpu_clk_en == !m_sleep, {tag, " R2 cpu_clk_en"}, 32'(cpu_clk_en), 32'(!m_sleep));
    chk({stat1, stat0} == exp_stat(m_sleep), {tag, " R2 status"}, 32'({stat1, stat0}), 32'(exp_stat(m_sleep)));
    chk(stby_req == m_stby, {tag, " R3 stby_req"}, 32'(stby_req), 32'(m_stby));
    chk(wake_pls == m_wake, {tag, " R4/R10 wake_pls"}, 32'(wake_pls), 32'(m_wake));
    chk(evt_code == m_code && evt_src == m_src, {tag, " R5 event regs"},
        32'({evt_src, evt_code}), 32'({m_src, m_code}));
    chk(ms_rdata == m_stop && per_clk_en == ~m_stop[NPER-1:0], {tag, " R7/R8 module stop"},
        ms_rdata, m_stop);
    chk(ckout_en == 1'b1, {tag, " R9 ckout_en"}, 32'(ckout_en), 32'd1);
  endtask

  // one clock: drive on falling edge, update model at rising edge, sample 2 ns later
  task automatic cyc(input bit ss, input bit sb, input bit bb, input logic [3:0] src,
                     input logic [CODE_W-1:0] code, input bit we, input logic [31:0] wd,
                     input bit por, input bit mr, input string tag);
    @(negedge clk);
    sleep_stb = ss; stby_sel = sb; blk_bit = bb;
    {nmi_req, irl_req, irq_req, per_req} = src;
    req_code = code; ms_we = we; ms_wdata = wd; por_req = por; mrst_req = mr;
    @(posedge clk);
    m_wake = 0; m_stby = 0;
    if (!m_sleep) begin
      if (!(por || mr) && ss) begin
        if (sb) m_stby = 1; else m_sleep = 1;
      end
    end else begin
      if (por || mr) m_sleep = 0;
      else if (src != 4'd0) begin
        m_sleep = 0; m_wake = 1; m_code = code; m_src = src;
      end
    end
    if (por) m_stop = 32'd0;
    else if (we) m_stop = wd;
    #2ns;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 4'd0, '0, 0, 32'd0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5117));
    rst_n = 0; por_req = 0; mrst_req = 0; sleep_stb = 0; stby_sel = 0; blk_bit = 0;
    nmi_req = 0; irq_req = 0; irl_req = 0; per_req = 0; req_code = '0;
    ms_we = 0; ms_wdata = '0;
    m_sleep = 0; m_stop = '0; m_code = '0; m_src = '0; m_wake = 0; m_stby = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #2ns;
    check_all("R1 reset state");

    // sleep entry, then wake with the interrupt-block bit set
    cyc(1, 0, 1, 4'd0, '0, 0, 32'd0, 0, 0, "R2 enter sleep");
    idle("R2 stay asleep");
    cyc(0, 0, 1, 4'b1000, 12'h1C0, 0, 32'd0, 0, 0, "R4 nmi wake blk=1");
    idle("R4 pulse ends");
    // standby select
    cyc(1, 1, 0, 4'd0, '0, 0, 32'd0, 0, 0, "R3 standby strobe");
    idle("R3 standby ends");
    // interrupts in run are not wake events
    cyc(0, 0, 0, 4'b0001, 12'h5A5, 0, 32'd0, 0, 0, "R10 run interrupt");
    // module stop: gate both serial channels, check during sleep
    cyc(0, 0, 0, 4'd0, '0, 1, 32'hC000_0000, 0, 0, "R7 stop serial channels");
    cyc(1, 0, 0, 4'd0, '0, 0, 32'd0, 0, 0, "R9 sleep keeps enables");
    // reset request and interrupt together: reset wins
    cyc(0, 0, 0, 4'b0100, 12'h2E0, 0, 32'd0, 0, 1, "R6 manual reset beats irq");
    cyc(1, 0, 0, 4'd0, '0, 0, 32'd0, 0, 0, "R6 re-enter sleep");
    cyc(0, 0, 0, 4'b0010, 12'h3F0, 1, 32'hFFFF_FFFF, 1, 0, "R8 por clears over write");
    cyc(1, 0, 0, 4'd0, '0, 0, 32'd0, 0, 0, "R5 sleep again");
    cyc(0, 0, 0, 4'b0011, 12'h6B1, 0, 32'd0, 0, 0, "R5 two classes wake");

    for (int k = 0; k < 3000; k++) begin
      bit ss, sb, bb, we, por, mr;
      logic [3:0] src;
      ss  = ($urandom % 5) == 0;
      sb  = ($urandom % 4) == 0;
      bb  = $urandom % 2;
      src = (($urandom % 6) == 0) ? 4'($urandom) : 4'd0;
      we  = ($urandom % 9) == 0;
      por = ($urandom % 80) == 0;
      mr  = ($urandom % 70) == 0;
      cyc(ss, sb, bb, src, CODE_W'($urandom), we, $urandom, por, mr, "random R2-R10");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule